// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the two cross-port interrupt flags for a dual-ported memory of 4K words by 16 bits. It watches the control and address inputs of both ports. The top two addresses serve as mailboxes, one for each direction. When one port writes its partner's mailbox, the partner's active-low interrupt asserts. The receiving port acknowledges the interrupt by reading that same mailbox location.

The mailbox words are stored in the ordinary memory array, which lies outside this block. The block never looks at data, so the 16-bit message means whatever software chooses. Collision arbitration and semaphores are also handled elsewhere. Both flags are registered on the common clock, so each set or clear is visible one cycle after the access that caused it.

Top module: `mbox_irq`

## Requirements
- R1: While reset is held and right after it is released, both `irq_a_n` and `irq_b_n` are high (deasserted).
- R2: A write by port B (`b_ce_n`=0, `b_we_n`=0) to address 0xFFE drives `irq_a_n` low on the next clock edge.
- R3: A write by port A (`a_ce_n`=0, `a_we_n`=0) to address 0xFFF drives `irq_b_n` low on the next clock edge.
- R4: An access by port A to 0xFFE with `a_ce_n`=0 and `a_oe_n`=0 returns `irq_a_n` high on the next clock edge, whatever the level of `a_we_n`.
- R5: An access by port B to 0xFFF with `b_ce_n`=0 and `b_oe_n`=0 returns `irq_b_n` high on the next clock edge, whatever the level of `b_we_n`.
- R6: If neither a set nor a clear applies to a flag, it keeps its value. This covers accesses to other addresses, accesses with output enable high, and idle cycles.
- R7: If a set and a clear of the same flag occur in the same cycle, the flag ends up asserted (low).
- R8: A flag is not set by a read of the mailbox (`we_n`=1), by a write with chip enable high, by a write to any other address, or by a port writing its own mailbox.
- R9: Each flag changes only as a result of its own set and clear conditions. Raising or clearing one flag leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_ce_n | input | 1 | Port A chip enable, active low |
| a_we_n | input | 1 | Port A read/write select, low means write |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | 12 | Port A word address |
| b_ce_n | input | 1 | Port B chip enable, active low |
| b_we_n | input | 1 | Port B read/write select, low means write |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | 12 | Port B word address |
| irq_a_n | output | 1 | Interrupt to port A, active low, raised by port B writing 0xFFE |
| irq_b_n | output | 1 | Interrupt to port B, active low, raised by port A writing 0xFFF |

## Verification
Each flag is a single stored bit, and each output is that bit inverted. A wrong internal state therefore appears at the matching interrupt pin on the very next clock edge. The faults to look for are a flag that drops a message, a flag that fires for the wrong port or address, and a clear that beats a simultaneous set. The bench sets up each of these cases and compares both pins one cycle after every access. A stuck or swapped flag would therefore be seen within one cycle of the access that exposes it.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_ce_n,
  input  logic          a_we_n,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic          b_ce_n,
  input  logic          b_we_n,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  output logic          irq_a_n,
  output logic          irq_b_n
);

  localparam logic [AW-1:0] TOP   = '1;
  localparam logic [AW-1:0] BOX_A = TOP - AW'(1);
  localparam logic [AW-1:0] BOX_B = TOP;

  logic a_pend, b_pend;
  logic set_a, clr_a, set_b, clr_b;

  assign set_a = !b_ce_n && !b_we_n && (b_addr == BOX_A);
  assign clr_a = !a_ce_n && !a_oe_n && (a_addr == BOX_A);
  assign set_b = !a_ce_n && !a_we_n && (a_addr == BOX_B);
  assign clr_b = !b_ce_n && !b_oe_n && (b_addr == BOX_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_pend <= 1'b0;
      b_pend <= 1'b0;
    end else begin
      if (set_a)      a_pend <= 1'b1;
      else if (clr_a) a_pend <= 1'b0;
      if (set_b)      b_pend <= 1'b1;
      else if (clr_b) b_pend <= 1'b0;
    end
  end

  assign irq_a_n = !a_pend;
  assign irq_b_n = !b_pend;

  a_r2_set_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_ce_n && !b_we_n && b_addr == BOX_A) |=> !irq_a_n);
  a_r3_set_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_ce_n && !a_we_n && a_addr == BOX_B) |=> !irq_b_n);
  a_r4_clr_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_ce_n && !a_oe_n && a_addr == BOX_A && (b_ce_n || b_we_n || b_addr != BOX_A)) |=> irq_a_n);
  a_r5_clr_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_ce_n && !b_oe_n && b_addr == BOX_B && (a_ce_n || a_we_n || a_addr != BOX_B)) |=> irq_b_n);
  a_r6_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_ce_n || a_oe_n || a_addr != BOX_A) && (b_ce_n || b_we_n || b_addr != BOX_A)) |=> $stable(irq_a_n));
  a_r6_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    ((b_ce_n || b_oe_n || b_addr != BOX_B) && (a_ce_n || a_we_n || a_addr != BOX_B)) |=> $stable(irq_b_n));
  a_r8_no_self_set: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a_n && (b_ce_n || b_we_n || b_addr != BOX_A)) |=> irq_a_n);

endmodule

// File: tb/mbox_irq_bench.sv
`timescale 1ns/1ps
module mbox_irq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_ce_n = 1, a_we_n = 1, a_oe_n = 1;
  logic b_ce_n = 1, b_we_n = 1, b_oe_n = 1;
  logic [11:0] a_addr = '0, b_addr = '0;
  logic irq_a_n, irq_b_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic ea; logic eb; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  mbox_irq u_mbox_irq (
    .clk(clk), .rst_n(rst_n),
    .a_ce_n(a_ce_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .b_ce_n(b_ce_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .irq_a_n(irq_a_n), .irq_b_n(irq_b_n));

  task automatic step(input logic ac, aw, ao, input logic [11:0] aa,
                      input logic bc, bw, bo, input logic [11:0] ba,
                      input logic ea, eb, input string tag);
    exp_t e;
    @(negedge clk);
    a_ce_n = ac; a_we_n = aw; a_oe_n = ao; a_addr = aa;
    b_ce_n = bc; b_we_n = bw; b_oe_n = bo; b_addr = ba;
    e.ea = ea; e.eb = eb; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input logic ea, eb, input string tag);
    step(1, 1, 1, 12'h000, 1, 1, 1, 12'h000, ea, eb, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_run++;
      if (irq_a_n !== e.ea || irq_b_n !== e.eb) begin
        n_fail++;
        $display("FAIL %s: irq_a_n/irq_b_n = %b%b, expected %b%b", e.tag, irq_a_n, irq_b_n, e.ea, e.eb);
      end
    end
  end

  initial begin
    #7;
    n_run++;
    if (irq_a_n !== 1'b1 || irq_b_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 in reset: %b%b, expected 11", irq_a_n, irq_b_n);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(1, 1, "R1 after reset");
    idle(1, 1, "R6 idle");
    step(1,1,1,12'h000, 0,1,0,12'hFFE, 1,1, "R8 B reads 0xFFE");
    step(1,1,1,12'h000, 1,0,1,12'hFFE, 1,1, "R8 B write with ce high");
    step(1,1,1,12'h000, 0,0,1,12'hFFD, 1,1, "R8 B writes 0xFFD");
    step(1,1,1,12'h000, 0,0,1,12'hFFF, 1,1, "R8 B writes own box");
    step(0,0,1,12'hFFE, 1,1,1,12'h000, 1,1, "R8 A writes own box");
    step(1,1,1,12'h000, 0,0,1,12'hFFE, 0,1, "R2 B writes 0xFFE");
    idle(0, 1, "R6 hold set");
    step(0,1,1,12'hFFE, 1,1,1,12'h000, 0,1, "R6 A access oe high");
    step(0,1,0,12'hFFD, 1,1,1,12'h000, 0,1, "R6 A reads other addr");
    step(1,1,0,12'hFFE, 1,1,1,12'h000, 0,1, "R6 A ce high");
    step(0,0,1,12'hFFF, 1,1,1,12'h000, 0,0, "R3 A writes 0xFFF");
    step(1,1,1,12'h000, 0,1,0,12'hFFF, 0,1, "R5 B reads 0xFFF");
    step(0,1,0,12'hFFE, 1,1,1,12'h000, 1,1, "R4 A reads 0xFFE");
    step(1,1,1,12'h000, 0,0,1,12'hFFE, 0,1, "R2 set again");
    step(0,0,0,12'hFFE, 1,1,1,12'h000, 1,1, "R4 A clears with we low");
    step(0,1,0,12'hFFE, 0,0,1,12'hFFE, 0,1, "R7 set+clear from clear");
    step(0,1,0,12'hFFE, 0,0,1,12'hFFE, 0,1, "R7 set+clear while set");
    step(0,1,0,12'hFFE, 1,1,1,12'h000, 1,1, "R4 clear after R7");
    step(0,0,1,12'hFFF, 0,1,0,12'hFFF, 1,0, "R7 B set+clear");
    step(0,0,1,12'hFFF, 1,1,1,12'h000, 1,0, "R9 A writes 0xFFF again");
    step(1,1,1,12'h000, 0,0,0,12'hFFF, 1,1, "R5 B clears with we low");
    step(0,0,1,12'hFFF, 0,0,1,12'hFFE, 0,0, "R9 both set together");
    step(0,1,0,12'hFFE, 1,1,1,12'h000, 1,0, "R9 clear A only");
    step(1,1,1,12'h000, 0,1,0,12'hFFF, 1,1, "R9 clear B only");
    idle(1, 1, "R6 final idle");
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #20000; n_run++; n_fail++; $display("FAIL watchdog: timeout, expected completion"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule